// File: doc/BRIEF.md
# Zero-Overhead Loop Instruction Cache Controller

This block sits beside the fetch stage of a small 16-bit DSP sequencer and runs tight instruction loops with no branch instructions in them. A loop instruction names a body length and a pass count. On the first pass the body words come from program memory and each one is copied into a 15-entry on-chip instruction cache. Every later pass is served from that cache. While a loop is running, the block supplies the next program address each cycle, so it wraps at the end of a pass and leaves after the last pass with no extra cycles.

A replay form of the same instruction, with a body length of zero, runs the most recently cached body again with a new pass count. It does not refetch the body from memory. When the replay finishes, execution continues after the replay instruction. For each issued instruction the block reports the word to execute, whether that word came from the cache, the next program address, the cycle cost of the instruction, and whether a loop is in progress.

Top module: `zol_ctrl`

## Requirements
- R1: An instruction word is a loop instruction when bits 15:11 equal 0x0E. Bits 10:7 hold the body length and bits 6:0 hold the pass count. Any other word issued outside a loop executes from memory with next address pc+1, a cost of 1 cycle and busy low.
- R2: A loop instruction with a nonzero body length costs 1 cycle and gives next address pc+1. The body is the words at pc+1 through pc+length. busy is high from the next issued instruction.
- R3: On the first pass, the body words are taken from `mem_word_i` and executed with `use_cache_o` low. On every later pass, `exec_word_o` returns the stored word for each address with `use_cache_o` high, whatever is on `mem_word_i`.
- R4: The body runs as many passes as the pass count, and a count of 0 runs one pass. At the end of a pass that is not the last, the next address is the first body address.
- R5: At the end of the last pass of a loop, the next address is the loop instruction's pc+1+length and busy falls.
- R6: A loop instruction with a body length of zero, issued while a cached body exists, is a replay. It costs 2 cycles and gives as next address the first body address of the most recent loop. It then runs the requested passes entirely from the cache and exits to the replay instruction's pc+1.
- R7: A replay issued when no body has been cached since reset is treated as a plain 1-cycle instruction with next address pc+1 that starts no loop.
- R8: A word with the loop opcode met inside a running loop body is not decoded. It executes as a plain body word with a cost of 1 cycle.
- R9: In a cycle with `step_i` low, the loop state does not advance.
- R10: After reset, busy and `use_cache_o` are low and no cached body exists.
- R11: A body of the full 15 words is captured and replayed correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | One instruction issues this cycle |
| pc_i | input | 16 | Address of the issuing instruction |
| mem_word_i | input | 16 | Word fetched from program memory at `pc_i` |
| exec_word_o | output | 16 | Word to execute (memory or cache) |
| use_cache_o | output | 1 | High when `exec_word_o` comes from the cache |
| next_pc_o | output | 16 | Address of the next instruction |
| insn_cycles_o | output | 2 | Cycle cost of the issuing instruction (1 or 2) |
| busy_o | output | 1 | A loop is in progress |

## Verification
The hardest situations to reach from the ports are a cached pass that must not depend on memory at all and a replay that has to find a body captured by an earlier, already finished loop. To separate memory from cache, the stimulus drives a fixed poison word on `mem_word_i` during every pass it expects to be served from the cache, so a wrong source shows up in `exec_word_o`. The sequence also places a loop-opcode word inside a body and pauses issue in the middle of a pass. It then replays a block after another loop has overwritten the cache, and issues a replay right after a reset taken while a loop was running.

// File: rtl/zol_pkg.sv
package zol_pkg;
  // opcode value that marks the loop / replay instruction
  localparam logic [4:0] LOOP_OPC = 5'h0E;

  // what the issuing instruction does to the controller
  typedef enum logic [1:0] {
    ACT_PLAIN = 2'd0,
    ACT_DO    = 2'd1,
    ACT_REDO  = 2'd2,
    ACT_BODY  = 2'd3
  } act_e;
endpackage

// File: rtl/zol_rst_sync.sv
module zol_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/zol_decode.sv
module zol_decode #(
  parameter int DW   = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7
) (
  input  logic [DW-1:0]   word_i,
  output logic            hit_o,
  output logic [NI_W-1:0] ni_o,
  output logic [K_W-1:0]  k_o
);
  import zol_pkg::*;

  localparam int OPC_LSB = NI_W + K_W;

  assign hit_o = (word_i[DW-1:OPC_LSB] == LOOP_OPC);
  assign ni_o  = word_i[OPC_LSB-1:K_W];
  assign k_o   = word_i[K_W-1:0];
endmodule

// File: rtl/zol_cache.sv
module zol_cache #(
  parameter int DW    = 16,
  parameter int DEPTH = 15,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DEPTH-1:0][DW-1:0] ents;

  // one enabled register per cache slot, no reset on storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    logic          ent_en;

    assign ent_en = we_i && (widx_i == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (ent_en) begin
        ent_q <= wdata_i;
      end
    end

    assign ents[g] = ent_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx_i == IDX_W'(i)) begin
        rdata_o = ents[i];
      end
    end
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq #(
  parameter int AW   = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [AW-1:0]   pc_i,
  input  logic            hit_i,
  input  logic [NI_W-1:0] ni_i,
  input  logic [K_W-1:0]  k_i,
  output logic            active_o,
  output logic            first_o,
  output logic [NI_W-1:0] idx_o,
  output logic            cache_we_o,
  output logic [AW-1:0]   next_pc_o,
  output logic [1:0]      cycles_o
);
  import zol_pkg::*;

  // state registers
  logic            active_q, active_d;
  logic            first_q,  first_d;
  logic [NI_W-1:0] idx_q,    idx_d;
  logic [NI_W-1:0] len_q,    len_d;
  logic [K_W-1:0]  cnt_q,    cnt_d;
  logic [AW-1:0]   start_q,  start_d;
  logic [AW-1:0]   exit_q,   exit_d;

  act_e            act;
  logic            pass_end;
  logic            last_pass;
  logic [K_W-1:0]  cnt_load;
  logic [AW-1:0]   pc_inc;

  assign pc_inc    = pc_i + AW'(1);
  assign pass_end  = (idx_q == (len_q - NI_W'(1)));
  assign last_pass = (cnt_q == '0);
  // counter is tested after each pass, so load one less; zero still gives one pass
  assign cnt_load  = (k_i == '0) ? '0 : (k_i - K_W'(1));

  // classify the issuing instruction
  always_comb begin
    if (active_q) begin
      act = ACT_BODY;
    end else if (hit_i && (ni_i != '0)) begin
      act = ACT_DO;
    end else if (hit_i && (len_q != '0)) begin
      act = ACT_REDO;
    end else begin
      act = ACT_PLAIN;
    end
  end

  // next-state and fetch-address logic
  always_comb begin
    active_d   = active_q;
    first_d    = first_q;
    idx_d      = idx_q;
    len_d      = len_q;
    cnt_d      = cnt_q;
    start_d    = start_q;
    exit_d     = exit_q;
    next_pc_o  = pc_inc;
    cycles_o   = 2'd1;
    cache_we_o = 1'b0;

    unique case (act)
      ACT_DO: begin
        if (step_i) begin
          active_d = 1'b1;
          first_d  = 1'b1;
          idx_d    = '0;
          len_d    = ni_i;
          cnt_d    = cnt_load;
          start_d  = pc_inc;
          exit_d   = pc_inc + AW'(ni_i);
        end
      end
      ACT_REDO: begin
        next_pc_o = start_q;
        cycles_o  = 2'd2;
        if (step_i) begin
          active_d = 1'b1;
          first_d  = 1'b0;
          idx_d    = '0;
          cnt_d    = cnt_load;
          exit_d   = pc_inc;
        end
      end
      ACT_BODY: begin
        cache_we_o = step_i && first_q;
        if (pass_end) begin
          if (last_pass) begin
            next_pc_o = exit_q;
            if (step_i) begin
              active_d = 1'b0;
              first_d  = 1'b0;
            end
          end else begin
            next_pc_o = start_q;
            if (step_i) begin
              cnt_d   = cnt_q - K_W'(1);
              idx_d   = '0;
              first_d = 1'b0;
            end
          end
        end else if (step_i) begin
          idx_d = idx_q + NI_W'(1);
        end
      end
      default: begin
        // plain instruction: defaults already hold
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      start_q  <= '0;
      exit_q   <= '0;
    end else begin
      active_q <= active_d;
      first_q  <= first_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      exit_q   <= exit_d;
    end
  end

  assign active_o = active_q;
  assign first_o  = first_q;
  assign idx_o    = idx_q;
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] mem_word_i,
  output logic [DW-1:0] exec_word_o,
  output logic          use_cache_o,
  output logic [AW-1:0] next_pc_o,
  output logic [1:0]    insn_cycles_o,
  output logic          busy_o
);
  localparam int DEPTH = (1 << NI_W) - 1;

  logic            rst_q_n;
  logic            dec_hit;
  logic [NI_W-1:0] dec_ni;
  logic [K_W-1:0]  dec_k;
  logic            active;
  logic            first;
  logic [NI_W-1:0] idx;
  logic            cache_we;
  logic [DW-1:0]   cache_rd;

  zol_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign use_cache_o = active && !first;
  assign exec_word_o = use_cache_o ? cache_rd : mem_word_i;
  assign busy_o      = active;

  zol_decode #(.DW(DW), .NI_W(NI_W), .K_W(K_W)) u_dec (
    .word_i (exec_word_o),
    .hit_o  (dec_hit),
    .ni_o   (dec_ni),
    .k_o    (dec_k)
  );

  zol_seq #(.AW(AW), .NI_W(NI_W), .K_W(K_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .step_i     (step_i),
    .pc_i       (pc_i),
    .hit_i      (dec_hit),
    .ni_i       (dec_ni),
    .k_i        (dec_k),
    .active_o   (active),
    .first_o    (first),
    .idx_o      (idx),
    .cache_we_o (cache_we),
    .next_pc_o  (next_pc_o),
    .cycles_o   (insn_cycles_o)
  );

  zol_cache #(.DW(DW), .DEPTH(DEPTH), .IDX_W(NI_W)) u_cache (
    .clk     (clk),
    .we_i    (cache_we),
    .widx_i  (idx),
    .wdata_i (mem_word_i),
    .ridx_i  (idx),
    .rdata_o (cache_rd)
  );
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_i,
  input logic [AW-1:0] pc_i,
  input logic [DW-1:0] mem_word_i,
  input logic [DW-1:0] exec_word_o,
  input logic          use_cache_o,
  input logic [AW-1:0] next_pc_o,
  input logic [1:0]    insn_cycles_o,
  input logic          busy_o
);
  localparam int OPC_LSB = NI_W + K_W;

  logic loop_op;
  logic zero_len;

  assign loop_op  = (exec_word_o[DW-1:OPC_LSB] == 5'h0E);
  assign zero_len = (exec_word_o[OPC_LSB-1:K_W] == '0);

  // R1
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !busy_o && !loop_op) |-> (next_pc_o == pc_i + AW'(1) && insn_cycles_o == 2'd1));

  // R2
  do_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !busy_o && loop_op && !zero_len) |=> busy_o);

  // R3
  first_pass_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_cache_o) |-> (exec_word_o == mem_word_i));

  // R10
  cache_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_cache_o |-> busy_o);

  // R6
  redo_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_cycles_o == 2'd2) |-> (!busy_o && loop_op && zero_len));

  // R8
  body_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (insn_cycles_o == 2'd1));

  // R9
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(busy_o) && $stable(use_cache_o)));
endmodule

bind zol_ctrl zol_ctrl_chk #(.DW(DW), .AW(AW), .NI_W(NI_W), .K_W(K_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .step_i        (step_i),
  .pc_i          (pc_i),
  .mem_word_i    (mem_word_i),
  .exec_word_o   (exec_word_o),
  .use_cache_o   (use_cache_o),
  .next_pc_o     (next_pc_o),
  .insn_cycles_o (insn_cycles_o),
  .busy_o        (busy_o)
);

// File: tb/zol_ctrl_bench.sv
`timescale 1ns/1ps
module zol_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        step_i;
  logic [15:0] pc_i;
  logic [15:0] mem_word_i;
  logic [15:0] exec_word_o;
  logic        use_cache_o;
  logic [15:0] next_pc_o;
  logic [1:0]  insn_cycles_o;
  logic        busy_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  localparam logic [15:0] POISON = 16'hBAD0;

  typedef struct {
    logic [15:0] word;
    logic        src;
    logic [15:0] nxt;
    logic [1:0]  cyc;
    logic        busy;
    string       req;
  } item_t;

  item_t exp_q[$];

  zol_ctrl u_zol_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_i),
    .pc_i          (pc_i),
    .mem_word_i    (mem_word_i),
    .exec_word_o   (exec_word_o),
    .use_cache_o   (use_cache_o),
    .next_pc_o     (next_pc_o),
    .insn_cycles_o (insn_cycles_o),
    .busy_o        (busy_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] loop_word(input logic [3:0] ni, input logic [6:0] k);
    return {5'h0E, ni, k};
  endfunction

  // program memory contents: plain words, one loop-opcode word at 61
  function automatic logic [15:0] prog(input logic [15:0] a);
    if (a == 16'd61) return loop_word(4'd1, 7'd5);
    return {5'h03, a[10:0]};
  endfunction

  // driver: issue one instruction and push its expected result
  task automatic drive(input logic [15:0] pc, input logic [15:0] bus,
                       input logic [15:0] word, input logic src,
                       input logic [15:0] nxt, input logic [1:0] cyc,
                       input logic busy, input string req);
    item_t it;
    @(posedge clk); #1;
    step_i     = 1'b1;
    pc_i       = pc;
    mem_word_i = bus;
    it.word = word; it.src = src; it.nxt = nxt; it.cyc = cyc; it.busy = busy; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      step_i     = 1'b0;
      mem_word_i = POISON;
    end
  endtask

  // runs every pass of a loop body; cached passes see a poison memory bus
  task automatic run_loop(input logic [15:0] start, input int ni, input int npass,
                          input bit first_mem, input logic [15:0] exit_pc,
                          input bit pause, input string req);
    for (int p = 0; p < npass; p++) begin
      for (int i = 0; i < ni; i++) begin
        logic [15:0] a;
        logic        src;
        logic [15:0] nxt;
        a   = start + 16'(i);
        src = !(first_mem && p == 0);
        if (i == ni - 1) nxt = (p == npass - 1) ? exit_pc : start;
        else             nxt = a + 16'd1;
        if (pause && p == 1 && i == 0) idle(3);
        drive(a, src ? POISON : prog(a), prog(a), src, nxt, 2'd1, 1'b1, req);
      end
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    step_i = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per issued instruction
  always @(negedge clk) begin
    if (rst_n && step_i && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      vectors++;
      cmp(it.req, "exec_word", exec_word_o, it.word);
      cmp(it.req, "use_cache", 16'(use_cache_o), 16'(it.src));
      cmp(it.req, "next_pc", next_pc_o, it.nxt);
      cmp(it.req, "cycles", 16'(insn_cycles_o), 16'(it.cyc));
      cmp(it.req, "busy", 16'(busy_o), 16'(it.busy));
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    step_i     = 1'b0;
    pc_i       = '0;
    mem_word_i = '0;
    rst_n      = 1'b0;
    do_reset();

    // R10: reset state
    @(negedge clk);
    vectors++;
    cmp("R10", "busy", 16'(busy_o), 16'd0);
    cmp("R10", "use_cache", 16'(use_cache_o), 16'd0);

    // R1: plain words
    for (int a = 0; a < 3; a++)
      drive(16'(a), prog(16'(a)), prog(16'(a)), 1'b0, 16'(a + 1), 2'd1, 1'b0, "R1");

    // R7: replay with nothing cached
    drive(16'd5, loop_word(4'd0, 7'd3), loop_word(4'd0, 7'd3), 1'b0, 16'd6, 2'd1, 1'b0, "R7");
    drive(16'd6, prog(16'd6), prog(16'd6), 1'b0, 16'd7, 2'd1, 1'b0, "R7");

    // R2 R3 R4 R5 R9: body of 3, two passes, pause inside the second pass
    drive(16'd10, loop_word(4'd3, 7'd2), loop_word(4'd3, 7'd2), 1'b0, 16'd11, 2'd1, 1'b0, "R2");
    run_loop(16'd11, 3, 2, 1'b1, 16'd14, 1'b1, "R3_R4_R9");
    drive(16'd14, prog(16'd14), prog(16'd14), 1'b0, 16'd15, 2'd1, 1'b0, "R5");

    // R6: replay of cached body, three passes
    drive(16'd20, loop_word(4'd0, 7'd3), loop_word(4'd0, 7'd3), 1'b0, 16'd11, 2'd2, 1'b0, "R6");
    run_loop(16'd11, 3, 3, 1'b0, 16'd21, 1'b0, "R6");
    drive(16'd21, prog(16'd21), prog(16'd21), 1'b0, 16'd22, 2'd1, 1'b0, "R6");

    // R4: pass count 0 and 1 both give one pass
    drive(16'd30, loop_word(4'd1, 7'd0), loop_word(4'd1, 7'd0), 1'b0, 16'd31, 2'd1, 1'b0, "R4");
    run_loop(16'd31, 1, 1, 1'b1, 16'd32, 1'b0, "R4");
    drive(16'd32, loop_word(4'd1, 7'd1), loop_word(4'd1, 7'd1), 1'b0, 16'd33, 2'd1, 1'b0, "R4");
    run_loop(16'd33, 1, 1, 1'b1, 16'd34, 1'b0, "R4");

    // R11: full depth body
    drive(16'd40, loop_word(4'd15, 7'd2), loop_word(4'd15, 7'd2), 1'b0, 16'd41, 2'd1, 1'b0, "R11");
    run_loop(16'd41, 15, 2, 1'b1, 16'd56, 1'b0, "R11");
    drive(16'd56, prog(16'd56), prog(16'd56), 1'b0, 16'd57, 2'd1, 1'b0, "R11");

    // R8: loop-opcode word at 61 inside body is plain
    drive(16'd60, loop_word(4'd2, 7'd2), loop_word(4'd2, 7'd2), 1'b0, 16'd61, 2'd1, 1'b0, "R8");
    run_loop(16'd61, 2, 2, 1'b1, 16'd63, 1'b0, "R8");

    // R6: replay uses the most recent body (61..62)
    drive(16'd70, loop_word(4'd0, 7'd1), loop_word(4'd0, 7'd1), 1'b0, 16'd61, 2'd2, 1'b0, "R6");
    run_loop(16'd61, 2, 1, 1'b0, 16'd71, 1'b0, "R6");

    // R10 R7: reset mid-loop clears state and cached body
    drive(16'd90, loop_word(4'd2, 7'd4), loop_word(4'd2, 7'd4), 1'b0, 16'd91, 2'd1, 1'b0, "R2");
    drive(16'd91, prog(16'd91), prog(16'd91), 1'b0, 16'd92, 2'd1, 1'b1, "R3");
    idle(1);
    do_reset();
    drive(16'd80, loop_word(4'd0, 7'd2), loop_word(4'd0, 7'd2), 1'b0, 16'd81, 2'd1, 1'b0, "R10_R7");
    drive(16'd81, prog(16'd81), prog(16'd81), 1'b0, 16'd82, 2'd1, 1'b0, "R10_R7");
    idle(2);

    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL queue: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule